// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit turns the operand specification of one instruction into either an operand value or a physical memory address. A start pulse hands it an addressing mode code together with the register and instruction-field values the mode may need: a segment start register, a base register, an index register with a two-bit scale selector, an address field (displacement), the stack pointer, an immediate value and the value of a named register. Every address it forms includes the segment start, and all sums wrap at 32 bits.

For most modes the answer appears with a single-cycle done pulse one cycle after the start. The memory-indirect mode needs a pointer from memory first. The unit raises a read request at the segment start plus the address field and holds it until the memory answers with a valid pulse. One cycle later it reports the segment start plus the returned pointer. While such a fetch is pending the unit shows busy and discards any further start pulses.

Top module: `eag_unit`

## Requirements
- R1: Mode code 0 (immediate): one cycle after an accepted start, done is high, result equals the immediate input and res_is_addr is 0.
- R2: Mode code 1 (register): one cycle after an accepted start, done is high, result equals reg_val and res_is_addr is 0. No memory request is made.
- R3: Mode code 2 (direct): one cycle after an accepted start, done is high, res_is_addr is 1 and result equals seg_start + disp.
- R4: Mode code 3 (register indirect): one cycle after an accepted start, done is high, res_is_addr is 1 and result equals seg_start + base.
- R5: Mode code 4 (displacement): one cycle after an accepted start, done is high, res_is_addr is 1 and result equals seg_start + base + disp.
- R6: Mode code 5 (scaled index): one cycle after an accepted start, done is high, res_is_addr is 1 and result equals seg_start + base + disp + index × F. The scale codes 0, 1, 2 and 3 give F = 1, 2, 4 and 8.
- R7: Mode code 6 (stack): one cycle after an accepted start, done is high, res_is_addr is 1 and result equals seg_start + sp.
- R8: Mode code 7 (memory indirect): one cycle after an accepted start, mem_req rises with mem_addr = seg_start + disp. mem_req and mem_addr hold until mem_valid is sampled high. One cycle after that, mem_req is low, done is high, res_is_addr is 1 and result equals the segment start captured at start plus mem_rdata.
- R9: All address sums are taken modulo 2^32. Any carry out of bit 31 is dropped.
- R10: busy is high from the cycle after an indirect start until the cycle that shows its done. While busy is high, start pulses have no effect: they produce no done and they leave mem_req and mem_addr unchanged. A start that arrives in the same cycle as mem_valid is also ignored.
- R11: While reset is applied, done, busy and mem_req are 0. A mem_valid pulse while no request is pending has no effect.
- R12: done is high for exactly one cycle per accepted start, and never without one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begins one computation when the unit is not busy |
| mode | input | 3 | Addressing mode code (0 to 7, see R1 to R8) |
| seg_start | input | 32 | Segment start register value |
| base | input | 32 | Base register value |
| index | input | 32 | Index register value |
| scale | input | 2 | Index scale selector (factor 1, 2, 4, 8) |
| disp | input | 32 | Address field / displacement of the instruction |
| sp | input | 32 | Stack pointer value |
| imm | input | 32 | Immediate operand carried by the instruction |
| reg_val | input | 32 | Content of the register named by the instruction |
| mem_valid | input | 1 | Memory read data valid for the pending pointer read |
| mem_rdata | input | 32 | Pointer returned by memory |
| mem_req | output | 1 | Pointer read request, held until mem_valid |
| mem_addr | output | 32 | Address of the pointer read |
| busy | output | 1 | An indirect pointer fetch is pending |
| done | output | 1 | One-cycle pulse marking a valid result |
| res_is_addr | output | 1 | 1 when result is an address, 0 when it is an operand value |
| result | output | 32 | Operand value or physical address |

## Verification
Two events can fall in the same cycle: the memory returning the pointer, and a new start pulse. The bench drives start high in exactly the cycle it raises mem_valid, and also during the waiting cycles of a pending fetch. A reference model accepts only starts that arrive while no fetch is pending. The result is judged on whether done appears exactly once, carries the pointer sum, and matches the model on every following cycle. A stray mem_valid with no request pending is also driven, and must leave every output unchanged.

// File: rtl/eag_pkg.sv
package eag_pkg;
  typedef enum logic [2:0] {
    AM_IMM  = 3'd0,
    AM_REG  = 3'd1,
    AM_DIR  = 3'd2,
    AM_RIND = 3'd3,
    AM_DISP = 3'd4,
    AM_IDX  = 3'd5,
    AM_STK  = 3'd6,
    AM_PIND = 3'd7
  } amode_e;

  typedef enum logic {
    SQ_IDLE  = 1'b0,
    SQ_FETCH = 1'b1
  } seq_state_e;
endpackage

// File: rtl/eag_calc.sv
module eag_calc
  import eag_pkg::*;
#(
  parameter int W   = 32,
  parameter int SCW = 2
) (
  input  logic [2:0]     mode,
  input  logic [W-1:0]   seg_start,
  input  logic [W-1:0]   base,
  input  logic [W-1:0]   index,
  input  logic [SCW-1:0] scale,
  input  logic [W-1:0]   disp,
  input  logic [W-1:0]   sp,
  input  logic [W-1:0]   imm,
  input  logic [W-1:0]   reg_val,
  output logic [W-1:0]   value,
  output logic           is_addr,
  output logic           is_ind,
  output logic [W-1:0]   ptr_addr
);
  logic [W-1:0] scaled_idx;
  logic [W-1:0] seg_base;
  logic [W-1:0] seg_disp;

  // index times 2**scale, done as a shift; wraps at W bits
  assign scaled_idx = index << scale;
  assign seg_base   = seg_start + base;
  assign seg_disp   = seg_start + disp;
  assign ptr_addr   = seg_disp;
  assign is_ind     = (mode == AM_PIND);

  always_comb begin
    value   = '0;
    is_addr = 1'b1;
    case (amode_e'(mode))
      AM_IMM: begin
        value   = imm;
        is_addr = 1'b0;
      end
      AM_REG: begin
        value   = reg_val;
        is_addr = 1'b0;
      end
      AM_DIR:  value = seg_disp;
      AM_RIND: value = seg_base;
      AM_DISP: value = seg_base + disp;
      AM_IDX:  value = seg_base + disp + scaled_idx;
      AM_STK:  value = seg_start + sp;
      default: value = seg_disp;
    endcase
  end
endmodule

// File: rtl/eag_seq.sv
module eag_seq
  import eag_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         is_ind,
  input  logic [W-1:0] calc_value,
  input  logic         calc_is_addr,
  input  logic [W-1:0] ptr_addr,
  input  logic [W-1:0] seg_start,
  input  logic         mem_valid,
  input  logic [W-1:0] mem_rdata,
  output logic         done,
  output logic [W-1:0] result,
  output logic         res_is_addr,
  output logic         busy,
  output logic         mem_req,
  output logic [W-1:0] mem_addr
);
  seq_state_e   state_q, state_d;
  logic         done_q, done_d;
  logic         req_q, req_d;
  logic [W-1:0] res_q, res_d;
  logic         kind_q, kind_d;
  logic [W-1:0] addr_q, addr_d;
  logic [W-1:0] seg_q, seg_d;
  logic         res_en, addr_en;

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    req_d   = req_q;
    res_d   = res_q;
    kind_d  = kind_q;
    addr_d  = addr_q;
    seg_d   = seg_q;
    res_en  = 1'b0;
    addr_en = 1'b0;
    case (state_q)
      SQ_IDLE: begin
        if (start) begin
          if (is_ind) begin
            state_d = SQ_FETCH;
            req_d   = 1'b1;
            addr_d  = ptr_addr;
            seg_d   = seg_start;
            addr_en = 1'b1;
          end else begin
            done_d  = 1'b1;
            res_d   = calc_value;
            kind_d  = calc_is_addr;
            res_en  = 1'b1;
          end
        end
      end
      SQ_FETCH: begin
        if (mem_valid) begin
          state_d = SQ_IDLE;
          req_d   = 1'b0;
          done_d  = 1'b1;
          res_d   = seg_q + mem_rdata;
          kind_d  = 1'b1;
          res_en  = 1'b1;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      done_q  <= 1'b0;
      req_q   <= 1'b0;
      res_q   <= '0;
      kind_q  <= 1'b0;
      addr_q  <= '0;
      seg_q   <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      req_q   <= req_d;
      if (res_en) begin
        res_q  <= res_d;
        kind_q <= kind_d;
      end
      if (addr_en) begin
        addr_q <= addr_d;
        seg_q  <= seg_d;
      end
    end
  end

  assign done        = done_q;
  assign result      = res_q;
  assign res_is_addr = kind_q;
  assign busy        = (state_q == SQ_FETCH);
  assign mem_req     = req_q;
  assign mem_addr    = addr_q;

  // R8: a pending pointer read holds its request and address until answered
  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

  // R8: an answered read yields done on the next cycle
  assert_done_after_ret_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_valid) |=> (done && res_is_addr && !mem_req));

  // R10: done never shows while a fetch is pending
  assert_busy_no_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);
endmodule

// File: rtl/eag_unit.sv
module eag_unit
  import eag_pkg::*;
#(
  parameter int W   = 32,
  parameter int SCW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [2:0]     mode,
  input  logic [W-1:0]   seg_start,
  input  logic [W-1:0]   base,
  input  logic [W-1:0]   index,
  input  logic [SCW-1:0] scale,
  input  logic [W-1:0]   disp,
  input  logic [W-1:0]   sp,
  input  logic [W-1:0]   imm,
  input  logic [W-1:0]   reg_val,
  input  logic           mem_valid,
  input  logic [W-1:0]   mem_rdata,
  output logic           mem_req,
  output logic [W-1:0]   mem_addr,
  output logic           busy,
  output logic           done,
  output logic           res_is_addr,
  output logic [W-1:0]   result
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync_n;
  logic [W-1:0]           calc_value;
  logic                   calc_is_addr;
  logic                   calc_is_ind;
  logic [W-1:0]           ptr_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  eag_calc #(.W(W), .SCW(SCW)) u_calc (
    .mode      (mode),
    .seg_start (seg_start),
    .base      (base),
    .index     (index),
    .scale     (scale),
    .disp      (disp),
    .sp        (sp),
    .imm       (imm),
    .reg_val   (reg_val),
    .value     (calc_value),
    .is_addr   (calc_is_addr),
    .is_ind    (calc_is_ind),
    .ptr_addr  (ptr_addr)
  );

  eag_seq #(.W(W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .start        (start),
    .is_ind       (calc_is_ind),
    .calc_value   (calc_value),
    .calc_is_addr (calc_is_addr),
    .ptr_addr     (ptr_addr),
    .seg_start    (seg_start),
    .mem_valid    (mem_valid),
    .mem_rdata    (mem_rdata),
    .done         (done),
    .result       (result),
    .res_is_addr  (res_is_addr),
    .busy         (busy),
    .mem_req      (mem_req),
    .mem_addr     (mem_addr)
  );

  // R11: outputs quiet while reset is held
  always @(posedge clk) begin
    if (!rst_sync_n) begin
      assert_reset_quiet_R11: assert (!done && !busy && !mem_req);
    end
  end

  // R1: immediate operand passes through after one cycle
  assert_imm_pass_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (start && !busy && mode == AM_IMM) |=> (done && !res_is_addr && result == $past(imm)));

  // R2: register operand passes through, no memory request
  assert_reg_pass_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (start && !busy && mode == AM_REG) |=> (done && !res_is_addr && !mem_req && result == $past(reg_val)));

  // R10: a start during a pending fetch changes nothing
  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy && start && !mem_valid) |=> (busy && !done && $stable(mem_addr)));

  // R12: every done traces back to an accepted start or an answered read
  assert_done_cause_R12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |-> ($past(start && !busy && mode != AM_PIND) || $past(mem_req && mem_valid)));
endmodule

// File: tb/eag_unit_bench.sv
module eag_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [2:0]  mode;
  logic [31:0] seg_start, base, index, disp, sp, imm, reg_val, mem_rdata;
  logic [1:0]  scale;
  logic        mem_valid;
  logic        mem_req, busy, done, res_is_addr;
  logic [31:0] mem_addr, result;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  eag_unit u_eag_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .seg_start(seg_start), .base(base), .index(index), .scale(scale),
    .disp(disp), .sp(sp), .imm(imm), .reg_val(reg_val),
    .mem_valid(mem_valid), .mem_rdata(mem_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .busy(busy), .done(done),
    .res_is_addr(res_is_addr), .result(result)
  );

  // behavioural reference model
  bit          m_busy, m_done, m_req, m_kind;
  logic [31:0] m_res, m_addr, m_seg;
  string       m_tag;
  string       tags [8] = '{"R1", "R2", "R3", "R4", "R5", "R6 R9", "R7", "R8"};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_req = 0; m_kind = 0;
      m_res = 0; m_addr = 0; m_seg = 0; m_tag = "R11";
    end else begin
      m_done = 0;
      if (m_busy) begin
        if (mem_valid) begin
          m_busy = 0; m_req = 0; m_done = 1; m_kind = 1;
          m_res = m_seg + mem_rdata; m_tag = "R8";
        end
      end else if (start) begin
        m_tag = tags[mode];
        if (mode == 3'd7) begin
          m_busy = 1; m_req = 1; m_addr = seg_start + disp; m_seg = seg_start;
        end else begin
          m_done = 1;
          m_kind = (mode > 3'd1);
          case (mode)
            3'd0: m_res = imm;
            3'd1: m_res = reg_val;
            3'd2: m_res = seg_start + disp;
            3'd3: m_res = seg_start + base;
            3'd4: m_res = seg_start + base + disp;
            3'd5: m_res = seg_start + base + disp + index * (32'd1 << scale);
            default: m_res = seg_start + sp;
          endcase
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    chk(busy === m_busy, "R10 busy", {31'd0, busy}, {31'd0, m_busy});
    chk(mem_req === m_req, "R8 mem_req", {31'd0, mem_req}, {31'd0, m_req});
    if (m_req) chk(mem_addr === m_addr, "R8 mem_addr", mem_addr, m_addr);
    chk(done === m_done, m_done ? m_tag : "R12 done", {31'd0, done}, {31'd0, m_done});
    if (m_done) begin
      chk(result === m_res, m_tag, result, m_res);
      chk(res_is_addr === m_kind, m_tag, {31'd0, res_is_addr}, {31'd0, m_kind});
    end
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  task automatic op(input logic [2:0] md, input logic [31:0] sg, input logic [31:0] b,
                    input logic [31:0] ix, input logic [1:0] sc, input logic [31:0] d);
    mode = md; seg_start = sg; base = b; index = ix; scale = sc; disp = d;
    sp = sg ^ 32'h0000_1F00; imm = d ^ 32'hA5A5_0000; reg_val = b ^ 32'h0F0F_0F0F;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // indirect read: wait lat cycles, then return ptr; poke start while waiting and at return
  task automatic ind(input logic [31:0] sg, input logic [31:0] d, input int lat,
                     input logic [31:0] ptr, input bit poke);
    op(3'd7, sg, 32'h11, 32'h22, 2'd1, d);
    seg_start = ~sg;
    for (int i = 0; i < lat; i++) begin
      if (poke) begin mode = 3'd0; start = (i % 2 == 0); disp = disp + 1; end
      @(negedge clk);
      start = 1'b0;
    end
    mem_valid = 1'b1; mem_rdata = ptr;
    if (poke) begin start = 1'b1; mode = 3'd2; end
    @(negedge clk);
    mem_valid = 1'b0; start = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; start = 0; mode = 0; seg_start = 0; base = 0; index = 0;
    scale = 0; disp = 0; sp = 0; imm = 0; reg_val = 0; mem_valid = 0; mem_rdata = 0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(!done && !busy && !mem_req, "R11 reset", {29'd0, done, busy, mem_req}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1..R7 back to back
    for (int m = 0; m < 7; m++) op(m[2:0], 32'h0010_0000, 32'h0000_4000, 32'h10, 2'd2, 32'h42);
    // R6: all scale codes
    for (int s = 0; s < 4; s++) op(3'd5, 32'h00CD_9271, 32'h0014_5270, 32'd100, s[1:0], 32'h37);
    @(negedge clk);
    // R9: wraparound
    op(3'd5, 32'hFFFF_FFF0, 32'h0000_0020, 32'h8000_0001, 2'd3, 32'hFFFF_FFFF);
    op(3'd2, 32'hFFFF_FF00, 32'h0, 32'h0, 2'd0, 32'h0000_0200);
    // R8: immediate return, and long latency
    ind(32'h0000_1000, 32'h40, 0, 32'h0000_0123, 0);
    ind(32'h0002_0000, 32'h80, 3, 32'hFFFF_F000, 0);
    // R10: starts during fetch and at return cycle are ignored
    ind(32'h0300_0000, 32'h10, 4, 32'h0000_0777, 1);
    // R11: stray mem_valid with nothing pending
    mem_valid = 1'b1; mem_rdata = 32'hDEAD_BEEF;
    @(negedge clk);
    mem_valid = 1'b0;
    op(3'd1, 32'h5, 32'h1234_5678, 32'h0, 2'd0, 32'h0);
    // mixed traffic
    for (int k = 0; k < 60; k++) begin
      logic [2:0] md;
      md = 3'($urandom_range(0, 7));
      if (md == 3'd7)
        ind($urandom, $urandom, $urandom_range(0, 3), $urandom, 1'($urandom_range(0, 1)));
      else
        op(md, $urandom, $urandom, $urandom, 2'($urandom_range(0, 3)), $urandom);
      if (k % 3 == 0) @(negedge clk);
    end
    repeat (3) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule